// File: doc/BRIEF.md
# Vertical Interval and Field Detector

This block watches a composite sync signal and finds the vertical interval inside it. The sync has already been sliced and sampled and is active low. The block also reports whether the field that just began is odd or even. An up/down counter integrates the sync: every sample where sync is low adds one, and every sample where it is high takes one away. Ordinary line sync pulses and equalizing pulses are too short to carry the count far. A broad vertical pulse pushes it past a threshold and raises an internal vertical flag.

The edges of the vertical output come from sync rising edges. No free-running timer sets them. On each rising edge of sync, the output takes the state of the flag. The first serration after the flag rises therefore starts the pulse. The first rising edge after the flag drops ends it, and with normal timing that is the end of the second post-equalizing pulse. Some signals have no serrations. For those, a fallback counter starts the pulse once the flag has been set for a programmable number of cycles.

When the pulse ends, the block samples a line-rate horizontal reference from a companion window circuit and stores it as the field flag. Every timing value is a parameter counted in sample-clock cycles, so one design covers line rates from 15 to 130 kHz. A new sample arrives on every clock. The block has no stream handshake and nothing to back-pressure: all pins are plain levels.

Top module: `vsync_field_detector`

## Requirements
- R1: The integrator counts up by one for each clock where `csync_n` is sampled low and down by one for each clock where it is sampled high. It saturates at 0 and at `ACC_MAX`.
- R2: The vertical flag is set while the integrator value is at least `ACC_THRESH`. Normal line sync pulses (5 low in a 64-cycle line) and equalizing pulses (2 low in 32) never assert `vsync_n`.
- R3: A rising edge of `csync_n` is a low sample followed by a high sample. On each such edge, `vsync_n` is driven low if the flag is set and high if it is clear. The update appears two clocks after the first high sample is presented.
- R4: With serrations, using the bench timing (64-cycle lines, broad pulses 27 low / 5 high), `vsync_n` stays low for exactly 199 cycles. That runs from the first serration edge to the edge that ends the second post-equalizing pulse, and it is the same for odd and even fields.
- R5: If the flag stays set for `FALLBACK_CYC` consecutive clocks while `vsync_n` is high, `vsync_n` goes low without a sync edge, and R3 still ends the pulse. With the bench timing, a 187-cycle unbroken low gives a 143-cycle pulse.
- R6: `field_odd` loads `href` on the clock where `vsync_n` returns high, and holds its value at every other time. An `href` that is high in the second half of each line gives 1 for a field whose broad pulses start at a line start and 0 for one whose broad pulses start at mid-line.
- R7: Single-cycle noise pulses among the pre-equalizing pulses change neither `vsync_n` nor the field result.
- R8: A synchronous `rst` clears the integrator and drives `vsync_n` high and `field_odd` low on the next clock, even in the middle of a vertical interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| csync_n | input | 1 | Sliced composite sync sample, active low |
| href | input | 1 | Line-rate horizontal reference from the window circuit |
| vsync_n | output | 1 | Vertical sync, active low |
| field_odd | output | 1 | 1 for odd field, 0 for even field |

## Verification
On every cycle, the assertions check that the integrator stays within its ceiling and the fallback counter within its window. They also check that the vertical output only falls while the flag is set and only rises on a sync edge with the flag clear. The field flag must stay still except when the pulse ends. The pulse width in cycles, the odd/even result for each field phase, immunity to noise in the pre-equalizing region, and the delay of the fallback start can only be shown by the bench scenarios. They are compared against a behavioural model on every clock.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

  // Sync edge event plus the integrator's vertical flag, one per sample
  typedef struct packed {
    logic rise;   // low-to-high transition of sync seen this cycle
    logic flag;   // integrator at or above threshold
  } sync_evt_t;

endpackage

// File: rtl/vsd_integrator.sv
module vsd_integrator
  import vsd_pkg::*;
#(
  parameter int ACC_MAX    = 40,
  parameter int ACC_THRESH = 20
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      csync_n,
  output sync_evt_t evt
);

  localparam int ACC_W = $clog2(ACC_MAX + 1);
  localparam logic [ACC_W-1:0] CEIL = ACC_W'(ACC_MAX);
  localparam logic [ACC_W-1:0] THR  = ACC_W'(ACC_THRESH);

  logic             smp_q, smp_d;
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q <= 1'b1;
      smp_d <= 1'b1;
      acc_q <= '0;
    end else begin
      smp_q <= csync_n;
      smp_d <= smp_q;
      if (smp_q) begin
        if (acc_q != '0) acc_q <= acc_q - 1'b1;
      end else begin
        if (acc_q != CEIL) acc_q <= acc_q + 1'b1;
      end
    end
  end

  always_comb begin
    evt.rise = smp_q & ~smp_d;
    evt.flag = (acc_q >= THR);
  end

  AST_ACC_CEIL: assert property (@(posedge clk) disable iff (rst)
    acc_q <= CEIL); // R1

endmodule

// File: rtl/vsd_fallback.sv
module vsd_fallback #(
  parameter int FALLBACK_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic fire
);

  localparam int FB_W = $clog2(FALLBACK_CYC + 1);
  localparam logic [FB_W-1:0] LAST = FB_W'(FALLBACK_CYC - 1);

  logic [FB_W-1:0] cnt_q;

  assign fire = arm && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !arm || fire) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  AST_FB_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R5

endmodule

// File: rtl/vsd_vpulse.sv
module vsd_vpulse
  import vsd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  sync_evt_t evt,
  input  logic      fire,
  input  logic      href,
  output logic      vsync_n,
  output logic      field_odd
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vsync_n   <= 1'b1;
      field_odd <= 1'b0;
    end else if (evt.rise) begin
      vsync_n <= ~evt.flag;
      if (!evt.flag && !vsync_n) field_odd <= href;
    end else if (fire) begin
      vsync_n <= 1'b0;
    end
  end

  AST_START_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $fell(vsync_n) |-> $past(evt.flag)); // R3
  AST_END_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync_n) |-> $past(evt.rise && !evt.flag)); // R3
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$rose(vsync_n) |-> $stable(field_odd)); // R6

endmodule

// File: rtl/vsync_field_detector.sv
module vsync_field_detector
  import vsd_pkg::*;
#(
  parameter int ACC_MAX      = 40,
  parameter int ACC_THRESH   = 20,
  parameter int FALLBACK_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic csync_n,
  input  logic href,
  output logic vsync_n,
  output logic field_odd
);

  sync_evt_t evt;
  logic      fb_arm;
  logic      fb_fire;

  vsd_integrator #(
    .ACC_MAX   (ACC_MAX),
    .ACC_THRESH(ACC_THRESH)
  ) u_integ (
    .clk    (clk),
    .rst    (rst),
    .csync_n(csync_n),
    .evt    (evt)
  );

  assign fb_arm = evt.flag & vsync_n;

  vsd_fallback #(
    .FALLBACK_CYC(FALLBACK_CYC)
  ) u_fallback (
    .clk (clk),
    .rst (rst),
    .arm (fb_arm),
    .fire(fb_fire)
  );

  vsd_vpulse u_vpulse (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .fire     (fb_fire),
    .href     (href),
    .vsync_n  (vsync_n),
    .field_odd(field_odd)
  );

endmodule

// File: tb/vsync_field_detector_bench.sv
module vsync_field_detector_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AMAX = 40;
  localparam int ATHR = 20;
  localparam int FBC  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csync_n = 1'b1;
  logic href = 1'b0;
  logic vsync_n, field_odd;

  int total = 0, bad = 0, ph = 0, lowcnt = 0, cyc = 0;
  int m_s1 = 1, m_s2 = 1, m_acc = 0, m_vs = 1, m_odd = 0, m_fb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsync_field_detector #(.ACC_MAX(AMAX), .ACC_THRESH(ATHR), .FALLBACK_CYC(FBC))
    u_vsync_field_detector (
      .clk(clk), .rst(rst), .csync_n(csync_n), .href(href),
      .vsync_n(vsync_n), .field_odd(field_odd));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference, evaluated on each rising edge
  always @(posedge clk) begin : model
    int f, r, fire, ov;
    if (rst) begin
      m_s1 = 1; m_s2 = 1; m_acc = 0; m_vs = 1; m_odd = 0; m_fb = 0;
    end else begin
      f    = (m_acc >= ATHR) ? 1 : 0;
      r    = (m_s1 == 1 && m_s2 == 0) ? 1 : 0;
      ov   = m_vs;
      fire = (ov == 1 && f == 1 && m_fb == FBC - 1) ? 1 : 0;
      if (r == 1) begin
        if (f == 0 && ov == 0) m_odd = int'(href);
        m_vs = (f == 1) ? 0 : 1;
      end else if (fire == 1) m_vs = 0;
      m_fb = (ov == 1 && f == 1 && fire == 0) ? m_fb + 1 : 0;
      if (m_s1 == 1) m_acc = (m_acc > 0) ? m_acc - 1 : 0;
      else           m_acc = (m_acc < AMAX) ? m_acc + 1 : AMAX;
      m_s2 = m_s1;
      m_s1 = int'(csync_n);
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(int'(vsync_n) == m_vs, "R3 vsync_n vs model", int'(vsync_n), m_vs);
      chk(int'(field_odd) == m_odd, "R6 field_odd vs model", int'(field_odd), m_odd);
    end
    if (vsync_n == 1'b0) lowcnt++;
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input logic c);
    @(negedge clk);
    csync_n = c;
    href = (ph >= 32);
    ph = (ph + 1) % 64;
  endtask

  task automatic pulse(input int lo, input int len);
    repeat (lo) step(1'b0);
    repeat (len - lo) step(1'b1);
  endtask

  task automatic field(input bit even_f, input bit fb_mode, input bit noisy);
    repeat (3) pulse(5, 64);
    if (even_f) pulse(5, 32);
    for (int i = 0; i < 6; i++) begin
      if (noisy && (i == 2 || i == 4)) begin
        pulse(2, 12);
        pulse(1, 20);
      end else pulse(2, 32);
    end
    chk(vsync_n == 1'b1, "R2 no trigger before broad pulses", int'(vsync_n), 1);
    lowcnt = 0;
    if (fb_mode) begin
      for (int k = 0; k < 187; k++) begin
        step(1'b0);
        if (k == 80)  chk(vsync_n == 1'b1, "R5 not yet started", int'(vsync_n), 1);
        if (k == 120) chk(vsync_n == 1'b0, "R5 fallback started", int'(vsync_n), 0);
      end
      repeat (5) step(1'b1);
    end else begin
      repeat (6) pulse(27, 32);
    end
    repeat (6) pulse(2, 32);
    repeat (3) pulse(5, 64);
    if (even_f) pulse(5, 32);
    if (fb_mode) chk(lowcnt == 143, "R1 R5 fallback pulse width", lowcnt, 143);
    else         chk(lowcnt == 199, "R4 pulse width", lowcnt, 199);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(vsync_n == 1'b1, "R8 reset vsync_n", int'(vsync_n), 1);
    chk(field_odd == 1'b0, "R8 reset field_odd", int'(field_odd), 0);

    field(1'b0, 1'b0, 1'b0);
    chk(field_odd == 1'b1, "R6 odd field", int'(field_odd), 1);
    field(1'b1, 1'b0, 1'b0);
    chk(field_odd == 1'b0, "R6 even field", int'(field_odd), 0);
    field(1'b0, 1'b0, 1'b1);
    chk(field_odd == 1'b1, "R7 noisy odd field", int'(field_odd), 1);
    field(1'b1, 1'b0, 1'b1);
    chk(field_odd == 1'b0, "R7 noisy even field", int'(field_odd), 0);
    field(1'b0, 1'b1, 1'b0);
    chk(field_odd == 1'b1, "R5 R6 fallback field", int'(field_odd), 1);

    // reset in the middle of a vertical interval
    repeat (3) pulse(5, 64);
    repeat (6) pulse(2, 32);
    repeat (3) pulse(27, 32);
    chk(vsync_n == 1'b0, "R3 inside interval", int'(vsync_n), 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(vsync_n == 1'b1, "R8 mid-interval reset vsync_n", int'(vsync_n), 1);
    chk(field_odd == 1'b0, "R8 mid-interval reset field_odd", int'(field_odd), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule